// File: doc/BRIEF.md
# Hybrid Jump-Counter Control Sequencer

This block is the control unit of a minimal accumulator processor. Its state register is a small binary counter. On each clock the counter does one of four things: it clears to the fetch state, it loads a branch target, it counts up by one, or it holds. The counter control signals come from the current state and the synchronized memory Wait handshake.

One state is special. In the operation-decode state the counter loads its next value from a four-entry jump table, and the two instruction opcode bits index that table. Every other transition is a hold, a count or a clear.

From the registered state the block decodes a one-hot state vector and the register-transfer strobes for the datapath:

- PC clear, PC increment and PC to MAR.
- IR address to MAR.
- AC to MBR.
- Memory request and write direction.

The raw reset and Wait inputs each pass through a synchronizer before any logic uses them.

The state encoding is fixed:

| State | Role |
|---|---|
| S0 | Fetch; the reset target |
| S1 to S3 | Instruction read |
| S4 | Decode |
| S5 to S7 | Load |
| S8 and S9 | Store |
| S10 to S12 | Add |
| S13 | Branch |

Codes 14 and 15 are unused. If the counter ever holds one of them, it clears back to S0 on the next edge.

Top module: `jump_seq_ctrl`

## Requirements
- R1: The reset input passes through a SYNC_STAGES-flop synchronizer (default 2). While the synchronized reset is high, the counter clears, so the state is 0 on the following edge. A raw reset that is asserted before edge k shows as state 0 after edge k+2.
- R2: Counter control priority is fixed. Clear beats load, load beats count, and with none of them asserted the state holds. At most one of ctl_clr, ctl_ld and ctl_cnt is high in any cycle.
- R3: In S4 the counter loads from the jump table, indexed by opcode: 00 goes to 5, 01 to 8, 10 to 10 and 11 to 13. Load is asserted in no other state.
- R4: In S0, S5, S8 and S10 the state always advances by one.
- R5: S1 and S3 advance by one only while the synchronized Wait is 1. S2, S6 and S11 advance by one only while it is 0. Otherwise these states hold.
- R6: S7, S12 and S13 always clear to 0. S9 clears to 0 when the synchronized Wait is 0 and holds while it is 1.
- R7: The Wait input passes through a SYNC_STAGES-flop synchronizer. A change of wait_in before edge k first affects a transition at edge k+2.
- R8: state_q is the counter value. Bit i of state_hot is 1 exactly when state_q equals i.
- R9: pc_clr equals the synchronized reset. pc_inc and pc_to_mar are 1 exactly in S0. ir_to_mar is 1 exactly in S4. ac_to_mbr is 1 exactly in S4 with opcode 01.
- R10: mem_req is 1 exactly in S1, S2, S5, S6, S8, S9, S11 and S12. mem_write is 1 exactly in S8 and S9; in the other request states it is 0, which selects a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Raw active-high reset, synchronized inside |
| wait_in | input | 1 | Raw memory Wait handshake, synchronized inside |
| opcode | input | 2 | Instruction opcode bits, the jump table index |
| state_q | output | 4 | Current counter state |
| state_hot | output | 16 | One-hot decoded state |
| ctl_clr | output | 1 | Resolved counter clear |
| ctl_ld | output | 1 | Resolved counter load |
| ctl_cnt | output | 1 | Resolved counter count |
| pc_clr | output | 1 | Force PC to zero |
| pc_inc | output | 1 | Increment PC |
| pc_to_mar | output | 1 | Copy PC into MAR |
| ir_to_mar | output | 1 | Copy the IR address field into MAR |
| ac_to_mbr | output | 1 | Copy AC into MBR (store decode) |
| mem_req | output | 1 | Memory request; also enables the address bus |
| mem_write | output | 1 | 1 = write, 0 = read, while a request is active |

## Verification
The state changes one edge after the cycle that holds its cause. The control and strobe outputs follow the state and the synchronized inputs in the same cycle. A change on wait_in or rst_in takes two edges to pass the synchronizer, so its effect on the state is due on the third edge.

The bench's behavioural model holds its own two-stage copies of the raw inputs and steps once per rising edge. All outputs are compared one nanosecond after each falling edge. By then the rising-edge update has settled, and the newly driven opcode has propagated into the strobes that depend on it.

A directed sequence parks the machine in S1 and raises wait_in. It then checks that the state is still 1 two edges later and is 2 after the third edge.

// File: rtl/jseq_pkg.sv
package jseq_pkg;
  localparam int unsigned ST_FETCH  = 0;
  localparam int unsigned ST_RD1    = 1;
  localparam int unsigned ST_RD2    = 2;
  localparam int unsigned ST_RD3    = 3;
  localparam int unsigned ST_DEC    = 4;
  localparam int unsigned ST_LDA    = 5;
  localparam int unsigned ST_LDB    = 6;
  localparam int unsigned ST_LDC    = 7;
  localparam int unsigned ST_STA    = 8;
  localparam int unsigned ST_STB    = 9;
  localparam int unsigned ST_ADA    = 10;
  localparam int unsigned ST_ADB    = 11;
  localparam int unsigned ST_ADC    = 12;
  localparam int unsigned ST_BRA    = 13;

  localparam int unsigned OP_STORE  = 1;

  // branch target for each opcode seen in the decode state
  function automatic int unsigned jump_entry(input int unsigned idx);
    case (idx)
      0:       return ST_LDA;
      1:       return ST_STA;
      2:       return ST_ADA;
      3:       return ST_BRA;
      default: return ST_FETCH;
    endcase
  endfunction
endpackage

// File: rtl/jseq_sync.sv
module jseq_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          INIT   = 1'b0
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  // power-up value lets the reset chain start asserted
  logic [STAGES-1:0] chain = {STAGES{INIT}};

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/jseq_jump_rom.sv
module jseq_jump_rom
  import jseq_pkg::*;
#(
  parameter int unsigned OP_W    = 2,
  parameter int unsigned STATE_W = 4
) (
  input  logic [OP_W-1:0]    op,
  output logic [STATE_W-1:0] target
);
  localparam int unsigned DEPTH = 1 << OP_W;

  logic [STATE_W-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign table_q[g] = STATE_W'(jump_entry(g));
  end

  assign target = table_q[op];
endmodule

// File: rtl/jseq_ctrl.sv
module jseq_ctrl
  import jseq_pkg::*;
#(
  parameter int unsigned STATE_W = 4
) (
  input  logic [STATE_W-1:0] state,
  input  logic               wait_s,
  input  logic               rst_s,
  output logic               clr,
  output logic               ld,
  output logic               cnt
);
  logic        clr_st, ld_st, cnt_st;
  int unsigned s_idx;

  always_comb begin
    s_idx  = int'(state);
    clr_st = 1'b0;
    ld_st  = 1'b0;
    cnt_st = 1'b0;
    case (s_idx)
      ST_FETCH, ST_LDA, ST_STA, ST_ADA: cnt_st = 1'b1;
      ST_RD1, ST_RD3:                   cnt_st = wait_s;
      ST_RD2, ST_LDB, ST_ADB:           cnt_st = ~wait_s;
      ST_DEC:                           ld_st  = 1'b1;
      ST_STB:                           clr_st = ~wait_s;
      ST_LDC, ST_ADC, ST_BRA:           clr_st = 1'b1;
      default:                          clr_st = 1'b1;  // unused codes recover
    endcase
  end

  // fixed precedence: clear, then load, then count
  assign clr = rst_s | clr_st;
  assign ld  = ld_st & ~clr;
  assign cnt = cnt_st & ~clr & ~ld;
endmodule

// File: rtl/jseq_counter.sv
module jseq_counter #(
  parameter int unsigned STATE_W = 4
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               ld,
  input  logic               cnt,
  input  logic [STATE_W-1:0] load_val,
  output logic [STATE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (clr)      q <= '0;
    else if (ld)  q <= load_val;
    else if (cnt) q <= q + 1'b1;
  end
endmodule

// File: rtl/jseq_decode.sv
module jseq_decode
  import jseq_pkg::*;
#(
  parameter int unsigned STATE_W = 4,
  parameter int unsigned OP_W    = 2
) (
  input  logic [STATE_W-1:0]      state,
  input  logic [OP_W-1:0]         op,
  input  logic                    rst_s,
  output logic [(1<<STATE_W)-1:0] hot,
  output logic                    pc_clr,
  output logic                    pc_inc,
  output logic                    pc_to_mar,
  output logic                    ir_to_mar,
  output logic                    ac_to_mbr,
  output logic                    mem_req,
  output logic                    mem_write
);
  localparam int unsigned NUM_ST = 1 << STATE_W;

  for (genvar g = 0; g < NUM_ST; g++) begin : g_hot
    assign hot[g] = (state == STATE_W'(g));
  end

  assign pc_clr    = rst_s;
  assign pc_inc    = hot[ST_FETCH];
  assign pc_to_mar = hot[ST_FETCH];
  assign ir_to_mar = hot[ST_DEC];
  assign ac_to_mbr = hot[ST_DEC] & (op == OP_W'(OP_STORE));
  assign mem_req   = hot[ST_RD1] | hot[ST_RD2] | hot[ST_LDA] | hot[ST_LDB]
                   | hot[ST_STA] | hot[ST_STB] | hot[ST_ADB] | hot[ST_ADC];
  assign mem_write = hot[ST_STA] | hot[ST_STB];
endmodule

// File: rtl/jump_seq_ctrl.sv
module jump_seq_ctrl #(
  parameter int unsigned STATE_W     = 4,
  parameter int unsigned OP_W        = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_in,
  input  logic                    wait_in,
  input  logic [OP_W-1:0]         opcode,
  output logic [STATE_W-1:0]      state_q,
  output logic [(1<<STATE_W)-1:0] state_hot,
  output logic                    ctl_clr,
  output logic                    ctl_ld,
  output logic                    ctl_cnt,
  output logic                    pc_clr,
  output logic                    pc_inc,
  output logic                    pc_to_mar,
  output logic                    ir_to_mar,
  output logic                    ac_to_mbr,
  output logic                    mem_req,
  output logic                    mem_write
);
  logic               rst_s;
  logic               wait_s;
  logic [STATE_W-1:0] jump_tgt;

  jseq_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) i_rst_sync (
    .clk(clk), .d(rst_in), .q(rst_s)
  );

  jseq_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) i_wait_sync (
    .clk(clk), .d(wait_in), .q(wait_s)
  );

  jseq_jump_rom #(.OP_W(OP_W), .STATE_W(STATE_W)) i_rom (
    .op(opcode), .target(jump_tgt)
  );

  jseq_ctrl #(.STATE_W(STATE_W)) i_ctrl (
    .state(state_q), .wait_s(wait_s), .rst_s(rst_s),
    .clr(ctl_clr), .ld(ctl_ld), .cnt(ctl_cnt)
  );

  jseq_counter #(.STATE_W(STATE_W)) i_cnt (
    .clk(clk), .clr(ctl_clr), .ld(ctl_ld), .cnt(ctl_cnt),
    .load_val(jump_tgt), .q(state_q)
  );

  jseq_decode #(.STATE_W(STATE_W), .OP_W(OP_W)) i_dec (
    .state(state_q), .op(opcode), .rst_s(rst_s), .hot(state_hot),
    .pc_clr(pc_clr), .pc_inc(pc_inc), .pc_to_mar(pc_to_mar),
    .ir_to_mar(ir_to_mar), .ac_to_mbr(ac_to_mbr),
    .mem_req(mem_req), .mem_write(mem_write)
  );
endmodule

// File: rtl/jseq_chk.sv
module jseq_chk #(
  parameter int unsigned STATE_W = 4
) (
  input logic                    clk,
  input logic                    rst_s,
  input logic [STATE_W-1:0]      state_q,
  input logic [(1<<STATE_W)-1:0] state_hot,
  input logic                    ctl_clr,
  input logic                    ctl_ld,
  input logic                    ctl_cnt,
  input logic                    mem_req,
  input logic                    mem_write
);
  p_reset_to_s0_r1: assert property (@(posedge clk)
    rst_s |=> (state_q == '0));

  p_clear_wins_r2: assert property (@(posedge clk) disable iff (rst_s)
    ctl_clr |=> (state_q == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst_s)
    (!ctl_clr && !ctl_ld && !ctl_cnt) |=> $stable(state_q));

  p_one_ctl_r2: assert property (@(posedge clk) disable iff (rst_s)
    $countones({ctl_clr, ctl_ld, ctl_cnt}) <= 1);

  p_decode_target_r3: assert property (@(posedge clk) disable iff (rst_s)
    (state_q == STATE_W'(4)) |=> (state_q == STATE_W'(5) || state_q == STATE_W'(8)
                                  || state_q == STATE_W'(10) || state_q == STATE_W'(13)));

  p_count_step_r4: assert property (@(posedge clk) disable iff (rst_s)
    ctl_cnt |=> (state_q == $past(state_q) + 1'b1));

  // unused codes also clear (R6 family)
  p_unused_recover_r6: assert property (@(posedge clk) disable iff (rst_s)
    (state_q >= STATE_W'(14)) |=> (state_q == '0));

  p_onehot_r8: assert property (@(posedge clk) disable iff (rst_s)
    ($countones(state_hot) == 1) && state_hot[state_q]);

  p_write_in_req_r10: assert property (@(posedge clk) disable iff (rst_s)
    mem_write |-> mem_req);
endmodule

bind jump_seq_ctrl jseq_chk #(.STATE_W(STATE_W)) i_chk (
  .clk(clk), .rst_s(rst_s), .state_q(state_q), .state_hot(state_hot),
  .ctl_clr(ctl_clr), .ctl_ld(ctl_ld), .ctl_cnt(ctl_cnt),
  .mem_req(mem_req), .mem_write(mem_write)
);

// File: tb/test_jump_seq_ctrl.sv
`timescale 1ns/1ps
module test_jump_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_in = 1'b1;
  logic        wait_in = 1'b0;
  logic [1:0]  opcode = 2'b00;
  logic [3:0]  state_q;
  logic [15:0] state_hot;
  logic ctl_clr, ctl_ld, ctl_cnt, pc_clr, pc_inc, pc_to_mar;
  logic ir_to_mar, ac_to_mbr, mem_req, mem_write;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  jump_seq_ctrl i_jump_seq_ctrl (
    .clk(clk), .rst_in(rst_in), .wait_in(wait_in), .opcode(opcode),
    .state_q(state_q), .state_hot(state_hot),
    .ctl_clr(ctl_clr), .ctl_ld(ctl_ld), .ctl_cnt(ctl_cnt),
    .pc_clr(pc_clr), .pc_inc(pc_inc), .pc_to_mar(pc_to_mar),
    .ir_to_mar(ir_to_mar), .ac_to_mbr(ac_to_mbr),
    .mem_req(mem_req), .mem_write(mem_write)
  );

  // reference model: two-stage input copies, state stepped per edge
  int m_state = 0, m_prev = 0;
  bit m_r1 = 1'b1, m_r2 = 1'b1, m_w1 = 1'b0, m_w2 = 1'b0, m_prev_r = 1'b1;

  function automatic int jump_of(input int op);
    case (op)
      0: return 5;
      1: return 8;
      2: return 10;
      default: return 13;
    endcase
  endfunction

  always @(posedge clk) begin
    m_prev   = m_state;
    m_prev_r = m_r2;
    if (m_r2) m_state = 0;
    else begin
      case (m_state)
        0, 5, 8, 10: m_state = m_state + 1;
        1, 3:        if (m_w2) m_state = m_state + 1;
        2, 6, 11:    if (!m_w2) m_state = m_state + 1;
        4:           m_state = jump_of(int'(opcode));
        9:           if (!m_w2) m_state = 0;
        default:     m_state = 0;
      endcase
    end
    m_r2 = m_r1; m_r1 = rst_in;
    m_w2 = m_w1; m_w1 = wait_in;
    cmp_en = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int s, input bit r);
    if (r) return "R1";
    case (s)
      4:           return "R3";
      0, 5, 8, 10: return "R4";
      1, 2, 3, 6, 11: return "R5";
      default:     return "R6";
    endcase
  endfunction

  // compare every cycle, clear of both the edge and the input drive
  always @(negedge clk) begin
    #1;
    if (cmp_en && !done) begin
      bit e_clr, e_ld, e_cnt, e_req, e_wr;
      e_clr = m_r2 || (m_state inside {7, 12, 13, 14, 15}) || (m_state == 9 && !m_w2);
      e_ld  = !e_clr && (m_state == 4);
      e_cnt = !e_clr && !e_ld && ((m_state inside {0, 5, 8, 10})
              || ((m_state inside {1, 3}) && m_w2)
              || ((m_state inside {2, 6, 11}) && !m_w2));
      e_req = m_state inside {1, 2, 5, 6, 8, 9, 11, 12};
      e_wr  = m_state inside {8, 9};
      chk(int'(state_q) == m_state, tag_of(m_prev, m_prev_r), int'(state_q), m_state);
      chk(state_hot == (16'h1 << m_state), "R8 onehot", int'(state_hot), 1 << m_state);
      chk({ctl_clr, ctl_ld, ctl_cnt} == {e_clr, e_ld, e_cnt}, "R2 ctl",
          int'({ctl_clr, ctl_ld, ctl_cnt}), int'({e_clr, e_ld, e_cnt}));
      chk({pc_clr, pc_inc, pc_to_mar, ir_to_mar, ac_to_mbr} ==
          {m_r2, m_state == 0, m_state == 0, m_state == 4,
           (m_state == 4) && (opcode == 2'b01)}, "R9 strobes",
          int'({pc_clr, pc_inc, pc_to_mar, ir_to_mar, ac_to_mbr}),
          int'({m_r2, m_state == 0, m_state == 0, m_state == 4,
                (m_state == 4) && (opcode == 2'b01)}));
      chk({mem_req, mem_write} == {e_req, e_wr}, "R10 mem",
          int'({mem_req, mem_write}), int'({e_req, e_wr}));
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    repeat (5) step();
    #1;
    chk(state_q == 4'd0, "R1 reset state", int'(state_q), 0);
    rst_in = 1'b0;
    // reach S1 with Wait low; it must park there
    for (int i = 0; i < 20 && state_q != 4'd1; i++) step();
    #1;
    chk(state_q == 4'd1, "R5 reach S1", int'(state_q), 1);
    repeat (3) step();
    #1;
    chk(state_q == 4'd1, "R5 hold S1", int'(state_q), 1);
    step();
    wait_in = 1'b1;
    repeat (2) step();
    #1;
    chk(state_q == 4'd1, "R7 sync latency", int'(state_q), 1);
    step();
    #1;
    chk(state_q == 4'd2, "R7 advance", int'(state_q), 2);
    // randomized traffic with occasional resets
    for (int n = 0; n < 4000; n++) begin
      step();
      if ($urandom_range(0, 3) == 0) wait_in = ~wait_in;
      opcode = 2'($urandom_range(0, 3));
      rst_in = ($urandom_range(0, 149) == 0);
    end
    rst_in = 1'b0;
    repeat (4) step();
    #2;
    finish_run();
  end
endmodule